// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block performs signed and unsigned integer division and remainder on XLEN-bit operands. It can also run them as half-width ("word") operations whose result is sign-extended back to XLEN bits. A caller presents the dividend, the divisor, a two-bit operation code and a word flag, and pulses `start`. The unit raises `busy` and later answers with a one-cycle `done` pulse, with the result on `result`.

The datapath is a radix-2 restoring divider. It works on operand magnitudes and produces one quotient bit per clock. A final cycle applies the signs and the word-mode extension. Two cases never trap and never enter the iterative loop, because their fixed results come straight from a bypass in the setup cycle:

- a zero divisor;
- the most negative value divided by minus one (signed).

Top module: `divrem_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero.
- R2: The operation code sets the function. Bit 0 set means unsigned and clear means signed. Bit 1 set returns the remainder and clear returns the quotient. For signed operations the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R3: Unsigned quotient and remainder treat both operands as non-negative binary values.
- R4: A zero divisor makes the quotient all ones, for both signed and unsigned operations.
- R5: A zero divisor makes the remainder equal to the dividend at the operation width.
- R6: A signed operation whose dividend is the most negative value at its width and whose divisor is all ones returns that most negative value as quotient and zero as remainder.
- R7: With `word` set, only the low XLEN/2 bits of each operand are used. They are sign-extended for signed operations and zero-extended for unsigned ones. The half-width result is sign-extended to XLEN bits, for unsigned operations as well.
- R8: Cases R4 to R6 raise `done` one clock edge after the accepted start. Every other operation raises `done` XLEN+2 edges after it (XLEN/2+2 in word mode), counting the start edge.
- R9: `done` lasts exactly one cycle. `busy` is high from the cycle after the accepted start through the `done` cycle, and low again afterwards.
- R10: A `start` that arrives while `busy` is high is ignored. The running operation still delivers its own result, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Bit 0: unsigned; bit 1: remainder |
| word | input | 1 | Half-width operation |
| dividend | input | XLEN | Dividend operand |
| divisor | input | XLEN | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | XLEN | Quotient or remainder, held until the next result |

## Verification
The bench builds the unit with its default XLEN of 64. This exercises the full 64-step loop and, through the word flag, the 32-step half-width path in the same build. Drawing divisors from zero, minus one, small values and shifted random values reaches the bypass cases and the sign fix-up at both widths. The latency of every operation is measured, so an off-by-one in the loop count or in the bypass shows up.

// File: rtl/divrem_unit.sv
module divrem_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            word,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int H  = XLEN / 2;
  localparam int CW = $clog2(XLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX, S_DONE} state_t;
  state_t state;

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] quo, rmd, dvs;
  logic            neg_q, neg_r, want_rem, word_q;

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] x, input logic w);
    return w ? {{H{x[H-1]}}, x[H-1:0]} : x;
  endfunction

  wire is_uns = op[0];
  wire is_rem = op[1];

  wire [XLEN-1:0] a_ext = word ? {{H{~is_uns & dividend[H-1]}}, dividend[H-1:0]} : dividend;
  wire [XLEN-1:0] b_ext = word ? {{H{~is_uns & divisor[H-1]}},  divisor[H-1:0]}  : divisor;
  wire neg_a = ~is_uns & a_ext[XLEN-1];
  wire neg_b = ~is_uns & b_ext[XLEN-1];
  wire [XLEN-1:0] mag_a = neg_a ? -a_ext : a_ext;
  wire [XLEN-1:0] mag_b = neg_b ? -b_ext : b_ext;

  wire [XLEN-1:0] min_val = word ? {{(H+1){1'b1}}, {(H-1){1'b0}}} : {1'b1, {(XLEN-1){1'b0}}};
  wire div_zero = (b_ext == '0);
  wire ovf      = ~is_uns & (a_ext == min_val) & (&b_ext);
  wire [XLEN-1:0] bypass_val = div_zero ? (is_rem ? a_ext : '1) : (is_rem ? '0 : a_ext);

  wire [XLEN:0] trial = {rmd, quo[XLEN-1]} - {1'b0, dvs};
  wire          fits  = ~trial[XLEN];

  wire [XLEN-1:0] signed_out = want_rem ? (neg_r ? -rmd : rmd) : (neg_q ? -quo : quo);

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      quo      <= '0;
      rmd      <= '0;
      dvs      <= '0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
      want_rem <= 1'b0;
      word_q   <= 1'b0;
      result   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (div_zero || ovf) begin
            result <= fit(bypass_val, word);
            state  <= S_DONE;
          end else begin
            quo      <= word ? {mag_a[H-1:0], {H{1'b0}}} : mag_a;
            rmd      <= '0;
            dvs      <= mag_b;
            neg_q    <= neg_a ^ neg_b;
            neg_r    <= neg_a;
            want_rem <= is_rem;
            word_q   <= word;
            cnt      <= word ? CW'(H) : CW'(XLEN);
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          rmd <= fits ? trial[XLEN-1:0] : {rmd[XLEN-2:0], quo[XLEN-1]};
          quo <= {quo[XLEN-2:0], fits};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= S_FIX;
        end
        S_FIX: begin
          result <= fit(signed_out, word_q);
          state  <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !word && !op[1] && divisor == '0) |=> (done && result == '1));
  assert_zero_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !word && op[1] && divisor == '0) |=> (done && result == $past(dividend)));
  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !word && !op[0] && divisor == '1 && dividend == {1'b1, {(XLEN-1){1'b0}}})
    |=> (done && result == (op[1] ? '0 : {1'b1, {(XLEN-1){1'b0}}})));
endmodule

// File: tb/divrem_unit_test.sv
module divrem_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic word = 1'b0;
  logic [63:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  divrem_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] o, input logic w);
    logic [63:0] ua, ub, r;
    longint sa, sb;
    ua = w ? {32'b0, a[31:0]} : a;
    ub = w ? {32'b0, b[31:0]} : b;
    sa = w ? longint'({{32{a[31]}}, a[31:0]}) : longint'(a);
    sb = w ? longint'({{32{b[31]}}, b[31:0]}) : longint'(b);
    if (o[0]) begin
      if (ub == 0) r = o[1] ? ua : '1;
      else         r = o[1] ? ua % ub : ua / ub;
    end else begin
      if (sb == 0) r = o[1] ? sa : -64'sd1;
      else if (sa == longint'(64'h8000000000000000) && sb == -1) r = o[1] ? 64'd0 : sa;
      else r = o[1] ? sa % sb : sa / sb;
    end
    return w ? {{32{r[31]}}, r[31:0]} : r;
  endfunction

  function automatic bit is_bypass(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] o, input logic w);
    if (w) return (b[31:0] == 0) || (!o[0] && a[31:0] == 32'h80000000 && b[31:0] == '1);
    return (b == 0) || (!o[0] && a == 64'h8000000000000000 && b == '1);
  endfunction

  function automatic string req_of(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] o, input logic w);
    logic [63:0] bz;
    bz = w ? {32'b0, b[31:0]} : b;
    if (bz == 0) return o[1] ? "R5" : "R4";
    if (is_bypass(a, b, o, w)) return "R6";
    if (w) return "R7";
    return o[0] ? "R3" : "R2";
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] o, input logic w);
    int edges;
    int exp_lat;
    @(negedge clk);
    dividend = a; divisor = b; op = o; word = w; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 200) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    exp_lat = is_bypass(a, b, o, w) ? 1 : (w ? XLEN/2 + 2 : XLEN + 2);
    check(req_of(a, b, o, w), result, model(a, b, o, w));
    check("R8", 64'(edges), 64'(exp_lat));
    @(negedge clk);
    check("R9", {62'b0, done, busy}, 64'b0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd2024);
    #(CLK_PERIOD * 2 + 1);
    check("R1", {62'b0, busy, done}, 64'b0);
    check("R1", result, 64'b0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 2; w++) begin
        run_op(64'd100, 64'd0, 2'(o), 1'(w));
        run_op(64'hFFFFFFF9, 64'hFFFFFFFFFFFFFFFF, 2'(o), 1'(w));
        run_op(64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 2'(o), 1'(w));
        run_op(64'h0000000080000000, 64'h00000000FFFFFFFF, 2'(o), 1'(w));
        run_op(64'hFFFFFFFFFFFFFFF9, 64'd2, 2'(o), 1'(w));
        run_op(64'd7, 64'hFFFFFFFFFFFFFFFE, 2'(o), 1'(w));
        run_op(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'(o), 1'(w));
        run_op(64'h1234567800000000, 64'hABCD000000000000, 2'(o), 1'(w));
      end
    end

    // R10: start while busy must not disturb the running operation
    @(negedge clk);
    dividend = 64'd1000; divisor = 64'd7; op = 2'b00; word = 1'b0; start = 1'b1;
    @(negedge clk);
    dividend = 64'd5; divisor = 64'd0; op = 2'b10; start = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R10", result, 64'd142);
    repeat (4) begin
      @(negedge clk);
      check("R10", {63'b0, done}, 64'b0);
    end

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [1:0] o;
      logic w;
      a = rnd64();
      case ($urandom % 8)
        0: b = 64'd0;
        1: b = 64'hFFFFFFFFFFFFFFFF;
        2: b = 64'($urandom % 16) - 64'd8;
        default: b = rnd64() >> ($urandom % 64);
      endcase
      if ($urandom % 10 == 0) a = ($urandom % 2) ? 64'h8000000000000000 : 64'hFFFFFFFF80000000;
      o = 2'($urandom % 4);
      w = 1'($urandom % 2);
      run_op(a, b, o, w);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule